// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is the serial slave side of a converter's control interface. Every transaction opens with one instruction byte. That byte chooses the direction, the number of data bytes (one to four) and the starting address within a sixteen-entry byte space. The port then moves that many bytes between the serial line and its register file, stepping the byte address after each one. The register file holds four registers:

- a read-only 24-bit conversion result;
- a 32-bit command register, whose decoded fields drive the block's outputs;
- a 24-bit offset calibration register;
- a 24-bit gain calibration register.

The serial clock is sampled in the system clock domain, and its edges are detected there. Write data is taken on each rising serial edge. Read data advances on each falling serial edge. A byte written to the command register takes effect at the falling edge that closes it, so later bytes of the same burst already see the new setting.

A parallel side port supplies the conversion result and a ready flag, and can load both calibration registers in one cycle.

Top module: `srif_port`

## Requirements
- R1: The instruction byte is shifted in MSB first on rising serial edges. Bit 7 selects read (1) or write (0), bits 6:5 give the count, bits 3:0 give the start address, and bit 4 is ignored.
- R2: A transaction moves count+1 data bytes. The byte that follows them is decoded as a new instruction.
- R3: The read map is as follows. Addresses 0..2 return the conversion result, most significant byte first. Addresses 4..7 return command bytes 3..0, and bit 7 of byte 3 returns the ready input. Addresses 8..10 return the offset register and 12..14 the gain register, most significant byte first. Addresses 3, 11 and 15 return 0x00.
- R4: Read data leaves on sdo MSB first and changes only after falling serial edges. Bit 7 of the first byte is present after the falling edge that ends the instruction byte. sdo is 0 whenever no read is in progress.
- R5: After each data byte the address moves by one and wraps modulo 16.
- R6: When command bit 26 (byte 3 bit 2) is 1, reads step downward. Writes always step upward.
- R7: A byte written to the command register reaches the field outputs one system clock after the falling serial edge that ends that byte, including bytes in the middle of a burst.
- R8: Command field layout:
  - Byte 3 bits 6..0 drive bias_on, refout_on, fmt_offset, unipolar, rd_down, lsb_first and alt_dout.
  - Byte 2 holds mode[7:5], gain[4:2] and chan[1:0].
  - Byte 1 holds turbo[7:5] and decim[12:8].
  - Byte 0 holds decim[7:0].
- R9: Writes to addresses 0..2, 3, 11 and 15 change nothing.
- R10: Writing 1 to bit 7 of command byte 3 produces a one-clock pulse on dsync_pulse. The bit is not stored.
- R11: Synchronous reset behaviour:
  - decim is set to 23 and every other command field to 0.
  - Both calibration registers are cleared.
  - The port waits for an instruction byte, even if reset arrives partway through a transaction.
- R12: cal_load copies both parallel calibration inputs. When a serial write to a calibration byte lands in the same cycle, the serial byte wins for that byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| conv_data | input | 24 | Conversion result |
| conv_ready | input | 1 | Ready flag returned in command byte 3 bit 7 |
| cal_load | input | 1 | Parallel load strobe for both calibration registers |
| cal_offset_in | input | 24 | Parallel offset calibration value |
| cal_gain_in | input | 24 | Parallel gain calibration value |
| dsync_pulse | output | 1 | One-clock pulse for a written sync bit |
| bias_on | output | 1 | Command bit 30 |
| refout_on | output | 1 | Command bit 29 |
| fmt_offset | output | 1 | Command bit 28 |
| unipolar | output | 1 | Command bit 27 |
| rd_down | output | 1 | Command bit 26, downward read stepping |
| lsb_first | output | 1 | Command bit 25 |
| alt_dout | output | 1 | Command bit 24 |
| mode | output | 3 | Command bits 23:21 |
| gain | output | 3 | Command bits 20:18 |
| chan | output | 2 | Command bits 17:16 |
| turbo | output | 3 | Command bits 15:13 |
| decim | output | 13 | Command bits 12:0 |

## Verification
A parallel calibration load and a serial commit to a calibration byte can fall in the same clock. The bench provokes this by raising cal_load on exactly the clock that detects the falling serial edge closing a write to address 9. It then reads all three offset bytes back and expects the serial byte in the middle lane and the parallel value in the outer lanes. A second pairing is a sync-bit write and a command-field update, which both happen at the same byte boundary. The bench's clock-by-clock model checks both outputs at that boundary.

// File: rtl/srif_pkg.sv
`timescale 1ns/1ps
package srif_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int RES_W     = 24;
    localparam int CMD_W     = 32;
    localparam int RES_BYTES = RES_W / BYTE_W;
    localparam int CMD_BYTES = CMD_W / BYTE_W;
    localparam int CNT_W     = 2;
    localparam int BITS_W    = $clog2(BYTE_W + 1);
    localparam int DECIM_W   = 13;

    // instruction byte field positions
    localparam int INS_DIR    = 7;
    localparam int INS_CNT_HI = 6;
    localparam int INS_CNT_LO = 5;

    // byte address bases
    localparam logic [ADDR_W-1:0] BASE_RES = 4'd0;
    localparam logic [ADDR_W-1:0] BASE_CMD = 4'd4;
    localparam logic [ADDR_W-1:0] BASE_OFF = 4'd8;
    localparam logic [ADDR_W-1:0] BASE_GN  = 4'd12;

    localparam logic [DECIM_W-1:0] DECIM_RST = 13'd23;
    localparam logic [CMD_W-1:0]   CMD_RST   = {{(CMD_W-DECIM_W){1'b0}}, DECIM_RST};

    typedef enum logic {PH_INSTR, PH_DATA} phase_e;

    typedef struct packed {
        phase_e             ph;
        logic               rd;
        logic [CNT_W-1:0]   left;
        logic [ADDR_W-1:0]  addr;
        logic [BITS_W-1:0]  bits;
        logic [BYTE_W-1:0]  sin;
        logic [BYTE_W-1:0]  sout;
    } seq_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [RES_W-1:0] off;
        logic [RES_W-1:0] gn;
        logic             dsync;
    } regs_t;
endpackage

// File: rtl/srif_edge.sv
`timescale 1ns/1ps
module srif_edge (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic rise,
    output logic fall
);
    logic line_d, line_q;

    always_comb begin
        line_d = line;
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= line_d;
    end

    assign rise = line & ~line_q;
    assign fall = ~line & line_q;
endmodule

// File: rtl/srif_regfile.sv
`timescale 1ns/1ps
module srif_regfile
    import srif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rdata,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              conv_ready,
    input  logic              cal_load,
    input  logic [RES_W-1:0]  cal_offset_in,
    input  logic [RES_W-1:0]  cal_gain_in,
    output logic [CMD_W-1:0]  cmd,
    output logic              dsync_pulse
);
    regs_t r_d, r_q;

    // next state: parallel load first, serial byte lane overrides it
    always_comb begin
        r_d       = r_q;
        r_d.dsync = 1'b0;
        if (cal_load) begin
            r_d.off = cal_offset_in;
            r_d.gn  = cal_gain_in;
        end
        for (int b = 0; b < RES_BYTES; b++) begin
            if (we && waddr == BASE_OFF + ADDR_W'(b))
                r_d.off[RES_W-1-b*BYTE_W -: BYTE_W] = wdata;
            if (we && waddr == BASE_GN + ADDR_W'(b))
                r_d.gn[RES_W-1-b*BYTE_W -: BYTE_W] = wdata;
        end
        for (int b = 0; b < CMD_BYTES; b++) begin
            if (we && waddr == BASE_CMD + ADDR_W'(b)) begin
                if (b == 0) begin
                    // top bit is a strobe only, never stored
                    r_d.cmd[CMD_W-2 -: BYTE_W-1] = wdata[BYTE_W-2:0];
                    r_d.dsync = wdata[BYTE_W-1];
                end else begin
                    r_d.cmd[CMD_W-1-b*BYTE_W -: BYTE_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.cmd   <= CMD_RST;
            r_q.off   <= '0;
            r_q.gn    <= '0;
            r_q.dsync <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // byte read mux; holes read as zero
    always_comb begin
        rdata = '0;
        for (int b = 0; b < RES_BYTES; b++) begin
            if (rd_addr == BASE_RES + ADDR_W'(b)) rdata = conv_data[RES_W-1-b*BYTE_W -: BYTE_W];
            if (rd_addr == BASE_OFF + ADDR_W'(b)) rdata = r_q.off[RES_W-1-b*BYTE_W -: BYTE_W];
            if (rd_addr == BASE_GN + ADDR_W'(b))  rdata = r_q.gn[RES_W-1-b*BYTE_W -: BYTE_W];
        end
        for (int b = 0; b < CMD_BYTES; b++) begin
            if (rd_addr == BASE_CMD + ADDR_W'(b)) begin
                if (b == 0) rdata = {conv_ready, r_q.cmd[CMD_W-2 -: BYTE_W-1]};
                else        rdata = r_q.cmd[CMD_W-1-b*BYTE_W -: BYTE_W];
            end
        end
    end

    assign cmd         = r_q.cmd;
    assign dsync_pulse = r_q.dsync;
endmodule

// File: rtl/srif_port.sv
`timescale 1ns/1ps
module srif_port
    import srif_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk,
    input  logic         sdi,
    output logic         sdo,
    input  logic [23:0]  conv_data,
    input  logic         conv_ready,
    input  logic         cal_load,
    input  logic [23:0]  cal_offset_in,
    input  logic [23:0]  cal_gain_in,
    output logic         dsync_pulse,
    output logic         bias_on,
    output logic         refout_on,
    output logic         fmt_offset,
    output logic         unipolar,
    output logic         rd_down,
    output logic         lsb_first,
    output logic         alt_dout,
    output logic [2:0]   mode,
    output logic [2:0]   gain,
    output logic [1:0]   chan,
    output logic [2:0]   turbo,
    output logic [12:0]  decim
);
    seq_t s_d, s_q;
    logic sclk_rise, sclk_fall;
    logic we;
    logic [ADDR_W-1:0] step_addr, rd_addr;
    logic [BYTE_W-1:0] rdata;
    logic [CMD_W-1:0]  cmd_q;
    logic              in_data;
    logic              byte_done;

    srif_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .line (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    srif_regfile u_regs (
        .clk           (clk),
        .rst           (rst),
        .we            (we),
        .waddr         (s_q.addr),
        .wdata         (s_q.sin),
        .rd_addr       (rd_addr),
        .rdata         (rdata),
        .conv_data     (conv_data),
        .conv_ready    (conv_ready),
        .cal_load      (cal_load),
        .cal_offset_in (cal_offset_in),
        .cal_gain_in   (cal_gain_in),
        .cmd           (cmd_q),
        .dsync_pulse   (dsync_pulse)
    );

    assign in_data   = (s_q.ph == PH_DATA);
    assign byte_done = (s_q.bits == BITS_W'(BYTE_W));

    always_comb begin
        s_d = s_q;
        we  = 1'b0;
        // reads may walk downward, writes never do
        step_addr = (s_q.rd && rd_down) ? s_q.addr - 1'b1 : s_q.addr + 1'b1;
        // look-ahead address for the byte loaded at the boundary
        rd_addr   = (s_q.ph == PH_INSTR) ? s_q.sin[ADDR_W-1:0] : step_addr;

        if (sclk_rise && !byte_done) begin
            s_d.sin  = {s_q.sin[BYTE_W-2:0], sdi};
            s_d.bits = s_q.bits + 1'b1;
        end

        if (sclk_fall) begin
            if (byte_done) begin
                s_d.bits = '0;
                if (s_q.ph == PH_INSTR) begin
                    s_d.ph   = PH_DATA;
                    s_d.rd   = s_q.sin[INS_DIR];
                    s_d.left = s_q.sin[INS_CNT_HI:INS_CNT_LO];
                    s_d.addr = s_q.sin[ADDR_W-1:0];
                    s_d.sout = s_q.sin[INS_DIR] ? rdata : '0;
                end else begin
                    we = !s_q.rd;
                    if (s_q.left == '0) begin
                        s_d.ph   = PH_INSTR;
                        s_d.rd   = 1'b0;
                        s_d.sout = '0;
                    end else begin
                        s_d.left = s_q.left - 1'b1;
                        s_d.addr = step_addr;
                        s_d.sout = s_q.rd ? rdata : '0;
                    end
                end
            end else if (in_data && s_q.rd) begin
                s_d.sout = {s_q.sout[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.ph   <= PH_INSTR;
            s_q.rd   <= 1'b0;
            s_q.left <= '0;
            s_q.addr <= '0;
            s_q.bits <= '0;
            s_q.sin  <= '0;
            s_q.sout <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo        = s_q.sout[BYTE_W-1];
    assign bias_on    = cmd_q[30];
    assign refout_on  = cmd_q[29];
    assign fmt_offset = cmd_q[28];
    assign unipolar   = cmd_q[27];
    assign rd_down    = cmd_q[26];
    assign lsb_first  = cmd_q[25];
    assign alt_dout   = cmd_q[24];
    assign mode       = cmd_q[23:21];
    assign gain       = cmd_q[20:18];
    assign chan       = cmd_q[17:16];
    assign turbo      = cmd_q[15:13];
    assign decim      = cmd_q[DECIM_W-1:0];
endmodule

// File: rtl/srif_chk.sv
`timescale 1ns/1ps
module srif_chk
    import srif_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fall,
    input logic              in_data,
    input logic              rd_q,
    input logic [CNT_W-1:0]  left_q,
    input logic [BITS_W-1:0] bits_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              sdo,
    input logic [CMD_W-1:0]  cmd_q,
    input logic              dsync_pulse
);
    logic boundary;
    assign boundary = fall && (bits_q == BITS_W'(BYTE_W)) && in_data;

    assert_bitcount_R1: assert property (@(posedge clk) disable iff (rst)
        bits_q <= BITS_W'(BYTE_W));

    assert_last_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (boundary && left_q == '0) |=> !in_data);

    assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!in_data || !rd_q) |-> !sdo);

    assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(sdo));

    assert_write_up_R6: assert property (@(posedge clk) disable iff (rst)
        (boundary && !rd_q && left_q != '0) |=> addr_q == $past(addr_q) + 1'b1);

    assert_read_down_R6: assert property (@(posedge clk) disable iff (rst)
        (boundary && rd_q && left_q != '0 && cmd_q[26]) |=> addr_q == $past(addr_q) - 1'b1);

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(cmd_q));

    assert_dsync_single_R10: assert property (@(posedge clk) disable iff (rst)
        dsync_pulse |=> !dsync_pulse);

    assert_reset_decim_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cmd_q[DECIM_W-1:0] == DECIM_RST);
endmodule

bind srif_port srif_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fall        (sclk_fall),
    .in_data     (in_data),
    .rd_q        (s_q.rd),
    .left_q      (s_q.left),
    .bits_q      (s_q.bits),
    .addr_q      (s_q.addr),
    .sdo         (sdo),
    .cmd_q       (cmd_q),
    .dsync_pulse (dsync_pulse)
);

// File: tb/tb_srif_port.sv
`timescale 1ns/1ps
module tb_srif_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, sclk = 1'b0, sdi = 1'b0, sdo;
    logic [23:0] conv = 24'hABCDEF;
    logic drdy = 1'b1, cal_load = 1'b0;
    logic [23:0] cal_off = '0, cal_gn = '0;
    logic dsync_pulse, bias_on, refout_on, fmt_offset, unipolar, rd_down, lsb_first, alt_dout;
    logic [2:0] mode, gain, turbo;
    logic [1:0] chan;
    logic [12:0] decim;

    srif_port dut (
        .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .conv_data(conv), .conv_ready(drdy), .cal_load(cal_load),
        .cal_offset_in(cal_off), .cal_gain_in(cal_gn), .dsync_pulse(dsync_pulse),
        .bias_on(bias_on), .refout_on(refout_on), .fmt_offset(fmt_offset),
        .unipolar(unipolar), .rd_down(rd_down), .lsb_first(lsb_first),
        .alt_dout(alt_dout), .mode(mode), .gain(gain), .chan(chan),
        .turbo(turbo), .decim(decim)
    );

    logic [31:0] dut_cmd;
    assign dut_cmd = {1'b0, bias_on, refout_on, fmt_offset, unipolar, rd_down, lsb_first,
                      alt_dout, mode, gain, chan, turbo, decim};

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0;
    logic [31:0] m_cmd = 32'h17;
    logic [23:0] m_off = '0, m_gn = '0;
    logic exp_sdo = 1'b0, exp_pulse = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rd(input int a);
        case (a & 15)
            0: return conv[23:16];
            1: return conv[15:8];
            2: return conv[7:0];
            4: return {drdy, m_cmd[30:24]};
            5: return m_cmd[23:16];
            6: return m_cmd[15:8];
            7: return m_cmd[7:0];
            8: return m_off[23:16];
            9: return m_off[15:8];
            10: return m_off[7:0];
            12: return m_gn[23:16];
            13: return m_gn[15:8];
            14: return m_gn[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_wr(input int a, input logic [7:0] b);
        case (a & 15)
            4: begin m_cmd[30:24] = b[6:0]; exp_pulse = b[7]; end
            5: m_cmd[23:16] = b;
            6: m_cmd[15:8] = b;
            7: m_cmd[7:0] = b;
            8: m_off[23:16] = b;
            9: m_off[15:8] = b;
            10: m_off[7:0] = b;
            12: m_gn[23:16] = b;
            13: m_gn[15:8] = b;
            14: m_gn[7:0] = b;
            default: ;
        endcase
    endtask

    // clock-by-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (cmp_en && !rst) begin
            chk("R4 sdo level", {31'd0, sdo}, {31'd0, exp_sdo});
            chk("R7 R8 command fields", dut_cmd, m_cmd);
            chk("R10 sync pulse", {31'd0, dsync_pulse}, {31'd0, exp_pulse});
            exp_pulse = 1'b0;
        end
    end

    task automatic up(input logic d, output logic s);
        @(negedge clk); sdi = d; sclk = 1'b1;
        @(negedge clk); s = sdo;
    endtask

    task automatic dn_begin();
        @(negedge clk); sclk = 1'b0;
    endtask

    task automatic dn_end();
        @(negedge clk);
    endtask

    task automatic txn(input string tag, input bit rd, input int n, input int a0,
                       input logic [31:0] wd, input bit b4 = 1'b0, input bit coll = 1'b0,
                       input logic [23:0] po = '0, input logic [23:0] pg = '0);
        logic [7:0] ins, cur, got;
        logic s;
        int a;
        ins = {rd, 2'(n - 1), b4, 4'(a0)};
        a = a0 & 15;
        cur = '0;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            up(ins[i], s);
            dn_begin();
            if (i == 0 && rd) begin cur = m_rd(a); exp_sdo = cur[7]; end
            dn_end();
        end
        for (int k = 0; k < n; k++) begin
            logic [7:0] wb, eb;
            wb = wd[31-8*k -: 8];
            eb = cur;
            for (int i = 7; i >= 0; i--) begin
                up(rd ? 1'b0 : wb[i], s);
                got[i] = s;
                dn_begin();
                if (i > 0) begin
                    if (rd) exp_sdo = cur[i-1];
                end else begin
                    if (coll && k == 0) begin
                        cal_load = 1'b1; cal_off = po; cal_gn = pg;
                        m_off = po; m_gn = pg;
                    end
                    if (!rd) m_wr(a, wb);
                    if (k == n - 1) exp_sdo = 1'b0;
                    else begin
                        a = (rd && m_cmd[26]) ? ((a + 15) & 15) : ((a + 1) & 15);
                        if (rd) begin cur = m_rd(a); exp_sdo = cur[7]; end
                    end
                end
                dn_end();
                cal_load = 1'b0;
            end
            if (rd) chk(tag, {24'd0, got}, {24'd0, eb});
        end
    endtask

    task automatic do_reset();
        cmp_en = 1'b0;
        @(negedge clk);
        rst = 1'b1; sclk = 1'b0; sdi = 1'b0; cal_load = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_cmd = 32'h17; m_off = '0; m_gn = '0;
        exp_sdo = 1'b0; exp_pulse = 1'b0;
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: got timeout expected completed run");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic s;
        do_reset();
        @(negedge clk);
        chk("R11 decim default", {19'd0, decim}, 32'd23);
        chk("R11 other fields zero", {13'd0, dut_cmd[31:13]}, 32'd0);
        chk("R11 sdo idle", {31'd0, sdo}, 32'd0);

        txn("R3 R2 command read", 1, 4, 4, 32'h0);
        txn("R8 single write", 0, 1, 5, 32'hA5000000);
        chk("R8 mode", {29'd0, mode}, 32'd5);
        chk("R8 gain", {29'd0, gain}, 32'd1);
        chk("R8 chan", {30'd0, chan}, 32'd1);

        txn("R7 R10 burst write", 0, 4, 4, 32'hC21BE12C);
        chk("R8 turbo", {29'd0, turbo}, 32'd7);
        chk("R8 decim", {19'd0, decim}, 32'h12C);
        drdy = 1'b0;
        txn("R10 sync bit not stored", 1, 1, 4, 32'h0);
        drdy = 1'b1;

        txn("R3 conversion read", 1, 3, 0, 32'h0);
        txn("R3 offset write", 0, 3, 8, 32'h12345600);
        txn("R3 offset read", 1, 3, 8, 32'h0);
        txn("R3 gain cal write", 0, 3, 12, 32'h9ABCDE00);
        txn("R3 gain cal read", 1, 3, 12, 32'h0);

        txn("R9 hole write", 0, 1, 11, 32'hFF000000);
        txn("R9 R3 hole read", 1, 1, 11, 32'h0);
        txn("R5 R9 wrap write", 0, 4, 14, 32'h55AA7733);
        txn("R5 R9 wrap read", 1, 4, 14, 32'h0);

        txn("R1 bit4 ignored", 1, 2, 9, 32'h0, 1'b1);

        txn("R6 set step-down", 0, 1, 4, 32'h04000000);
        chk("R6 rd_down output", {31'd0, rd_down}, 32'd1);
        txn("R6 read downward", 1, 4, 7, 32'h0);
        txn("R6 write upward", 0, 2, 6, 32'h3C5A0000);
        chk("R6 decim after upward write", {19'd0, decim}, 32'h1C5A);
        txn("R5 R6 downward wrap", 1, 3, 1, 32'h0);
        txn("R6 clear step-down", 0, 1, 4, 32'h00000000);

        @(negedge clk);
        cal_load = 1'b1; cal_off = 24'h0F0E0D; cal_gn = 24'h112233;
        m_off = 24'h0F0E0D; m_gn = 24'h112233;
        @(negedge clk);
        cal_load = 1'b0;
        txn("R12 parallel offset", 1, 3, 8, 32'h0);
        txn("R12 parallel gain", 1, 3, 12, 32'h0);
        txn("R12 collision write", 0, 1, 9, 32'h77000000, 1'b0, 1'b1, 24'hA1A2A3, 24'hB1B2B3);
        txn("R12 merged offset", 1, 3, 8, 32'h0);
        txn("R12 gain after collision", 1, 3, 12, 32'h0);

        txn("R11 setup", 0, 1, 5, 32'hFF000000);
        for (int i = 0; i < 3; i++) begin
            up(1'b1, s); dn_begin(); dn_end();
        end
        do_reset();
        @(negedge clk);
        chk("R11 gain cleared", {29'd0, gain}, 32'd0);
        txn("R11 R2 fresh instruction", 1, 4, 4, 32'h0);
        txn("R11 calibration cleared", 1, 3, 8, 32'h0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule